// File: doc/BRIEF.md
# Serial-Loaded Fractional-N Dither Controller

This block sits between a host microcontroller and a PLL whose divider values are set through parallel pins. The host sends one 12-bit word over three wires: a serial clock, serial data and a latch strobe. The block splits the word into a prescaler value, a swallow-count value and a fractional count. It then drives the PLL's parallel prescaler, swallow and reference-divider pins. The reference divider is fixed and the host cannot change it.

Fractional-N operation comes from time-averaging. The swallow value on the pins alternates between the programmed integer A and A+1. A repeating 24-slot frame sets the duty cycle. Each slot lasts `TICK_DIV` system clocks, and the fractional count chooses how many slots show A+1. One integer A step equals one full output-frequency step. One fractional count equals one twenty-fourth of that step.

The three host inputs are asynchronous. The block resynchronises them into the system clock domain and acts on their rising edges. New settings appear on the pins only when the latch strobe rises.

Top module: `frac_dither_ctrl`

## Requirements
- R1: After synchronous reset, `pll_m` and `pll_a` are 0 and `fault` is 0. The fractional count is also 0, so `pll_a` does not dither.
- R2: Serial data is sampled MSB first on each rising edge of `ser_clk`. When the latch rises, the last 12 bits shifted in are decoded as follows: bits 11..9 give M, bits 8..5 give A, and bits 4..0 give the fractional count.
- R3: `pll_m`, `pll_a` and `fault` do not change when `ser_clk` toggles and `ser_latch` does not rise. A partly shifted word never reaches the outputs.
- R4: `pll_r` always equals 4.
- R5: With a fractional count of 0, `pll_a` holds A steadily.
- R6: With a fractional count f between 1 and 24 and A below 15, `pll_a` equals A+1 for exactly f·`TICK_DIV` clocks in any window of 24·`TICK_DIV` consecutive clocks. In all other clocks of the window it equals A.
- R7: A fractional count above 24 is clamped to 24, so `pll_a` is always A+1, and `fault` is set.
- R8: When A is 15 and the fractional count is not zero, `pll_a` stays at 15 and never wraps to 0, and `fault` is set.
- R9: `fault` stays set until the next latched word that is valid, which clears it.
- R10: Each latch restarts the dither frame at slot 0. The first slot after a latch shows A+1 whenever the fractional count is not zero and A is below 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock (asynchronous) |
| ser_dat | input | 1 | Host serial data (asynchronous) |
| ser_latch | input | 1 | Host latch strobe (asynchronous) |
| pll_m | output | 3 | Prescaler value to the PLL |
| pll_a | output | 4 | Dithered swallow-count value to the PLL |
| pll_r | output | 4 | Fixed reference divider value |
| fault | output | 1 | Sticky range error for the last latched word |

## Verification
The assertions assume the host holds `ser_dat` steady for several system clocks around each serial clock edge. They also assume each serial clock level and each latch level lasts longer than the two-stage synchroniser, so every host edge is seen exactly once. The stimulus keeps each serial half-period at four system clocks and changes data only while the serial clock is low. It raises the latch only after a whole word has been shifted in, except in the partial-word case, where the latch is never raised.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    localparam int M_W       = 3;
    localparam int A_W       = 4;
    localparam int F_W       = 5;
    localparam int WORD_W    = M_W + A_W + F_W;
    localparam int R_W       = 4;
    localparam int R_FIXED   = 4;
    localparam int FRAC_MAX  = 24;
    localparam int PHASE_W   = $clog2(FRAC_MAX);
    localparam int A_TOP     = (1 << A_W) - 1;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic [F_W-1:0] frac;
    } fdc_word_t;

    function automatic logic [F_W-1:0] clamp_frac(input logic [F_W-1:0] f);
        return (int'(f) > FRAC_MAX) ? F_W'(FRAC_MAX) : f;
    endfunction

    function automatic logic word_bad(input fdc_word_t w);
        return (int'(w.frac) > FRAC_MAX) ||
               ((int'(w.a) == A_TOP) && (w.frac != '0));
    endfunction
endpackage

// File: rtl/fdc_serial_rx.sv
module fdc_serial_rx
    import fdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_clk,
    input  logic      ser_dat,
    input  logic      ser_latch,
    output logic      word_vld,
    output fdc_word_t word_out
);
    localparam int NSYNC = 3;

    logic [2:0] s1, s2, prev;
    logic       clk_rise, lat_rise;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= {ser_latch, ser_dat, ser_clk};
            s2   <= s1;
            prev <= s2;
        end
    end

    assign clk_rise = s2[0] & ~prev[0];
    assign lat_rise = s2[2] & ~prev[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            word_vld <= 1'b0;
            word_out <= '0;
        end else begin
            word_vld <= lat_rise;
            if (clk_rise)
                shreg <= {shreg[WORD_W-2:0], s2[1]};
            if (lat_rise)
                word_out <= fdc_word_t'(shreg);
        end
    end

    p_vld_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);
    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !lat_rise |=> $stable(word_out));
    initial if (NSYNC != 3) $error("sync depth");
endmodule

// File: rtl/fdc_decode.sv
module fdc_decode
    import fdc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  fdc_word_t      word_in,
    output logic [M_W-1:0] m_q,
    output logic [A_W-1:0] a_q,
    output logic [F_W-1:0] frac_q,
    output logic           err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            m_q    <= '0;
            a_q    <= '0;
            frac_q <= '0;
            err_q  <= 1'b0;
        end else if (load) begin
            m_q    <= word_in.m;
            a_q    <= word_in.a;
            frac_q <= clamp_frac(word_in.frac);
            err_q  <= word_bad(word_in);
        end
    end

    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        int'(frac_q) <= FRAC_MAX);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable({m_q, a_q, frac_q, err_q}));
    p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
        (load && int'(word_in.frac) > FRAC_MAX) |=> err_q);
    p_err_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (load && int'(word_in.frac) <= FRAC_MAX && int'(word_in.a) != A_TOP) |=> !err_q);
endmodule

// File: rtl/fdc_dither.sv
module fdc_dither
    import fdc_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic [A_W-1:0] a_base,
    input  logic [F_W-1:0] frac,
    output logic [A_W-1:0] a_out
);
    localparam int TC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TC_W-1:0]    tcnt;
    logic               tick;
    logic [PHASE_W-1:0] phase;
    logic               hi_slot;

    generate
        if (TICK_DIV > 1) begin : g_div
            always_ff @(posedge clk) begin
                if (rst || restart)
                    tcnt <= '0;
                else if (tick)
                    tcnt <= '0;
                else
                    tcnt <= tcnt + 1'b1;
            end
            assign tick = (int'(tcnt) == TICK_DIV - 1);
        end else begin : g_nodiv
            assign tcnt = '0;
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase <= '0;
        else if (tick)
            phase <= (int'(phase) == FRAC_MAX - 1) ? '0 : phase + 1'b1;
    end

    assign hi_slot = (PHASE_W'(phase) < PHASE_W'(frac)) && (int'(a_base) != A_TOP);
    assign a_out   = hi_slot ? a_base + 1'b1 : a_base;

    p_phase_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < FRAC_MAX);
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase == '0);
    p_zero_frac_r5: assert property (@(posedge clk) disable iff (rst)
        frac == '0 |-> a_out == a_base);
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        int'(a_base) == A_TOP |-> int'(a_out) == A_TOP);
endmodule

// File: rtl/frac_dither_ctrl.sv
module frac_dither_ctrl
    import fdc_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_latch,
    output logic [M_W-1:0] pll_m,
    output logic [A_W-1:0] pll_a,
    output logic [R_W-1:0] pll_r,
    output logic           fault
);
    logic           word_vld;
    fdc_word_t      word;
    logic [A_W-1:0] a_q;
    logic [F_W-1:0] frac_q;
    logic           load_d;

    fdc_serial_rx u_rx (
        .clk(clk), .rst(rst),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_latch(ser_latch),
        .word_vld(word_vld), .word_out(word)
    );

    fdc_decode u_dec (
        .clk(clk), .rst(rst), .load(word_vld), .word_in(word),
        .m_q(pll_m), .a_q(a_q), .frac_q(frac_q), .err_q(fault)
    );

    always_ff @(posedge clk) begin
        if (rst) load_d <= 1'b0;
        else     load_d <= word_vld;
    end

    fdc_dither #(.TICK_DIV(TICK_DIV)) u_dth (
        .clk(clk), .rst(rst), .restart(word_vld),
        .a_base(a_q), .frac(frac_q), .a_out(pll_a)
    );

    assign pll_r = R_W'(R_FIXED);

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (pll_a == a_q) || (pll_a == a_q + 1'b1));
    p_first_slot_r10: assert property (@(posedge clk) disable iff (rst)
        (load_d && frac_q != '0 && int'(a_q) != A_TOP) |-> pll_a == a_q + 1'b1);
endmodule

// File: tb/sim_frac_dither_ctrl.sv
`timescale 1ns/1ps
module sim_frac_dither_ctrl;
    localparam int DIV = 8;
    localparam int HP  = 4;

    logic clk = 0, rst = 1;
    logic ser_clk = 0, ser_dat = 0, ser_latch = 0;
    logic [2:0] pll_m;
    logic [3:0] pll_a, pll_r;
    logic fault;

    int total = 0, bad = 0;
    bit done = 0, busy = 0;

    typedef struct { int m; int a; int f; int fc; bit err; string tag; } exp_t;
    exp_t q[$];
    event go;

    always #5 clk = ~clk;

    frac_dither_ctrl #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .pll_m(pll_m), .pll_a(pll_a),
        .pll_r(pll_r), .fault(fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [11:0] w, input int n);
        for (int i = 11; i > 11 - n; i--) begin
            ser_dat = w[i];
            wait_clks(HP);
            ser_clk = 1;
            wait_clks(HP);
            ser_clk = 0;
        end
    endtask

    // driver: shift a word, push the expected result, hand to monitor
    task automatic send(input int m, input int a, input int f, input string tag);
        exp_t e;
        logic [11:0] w;
        w = {3'(m), 4'(a), 5'(f)};
        e.m = m; e.a = a; e.f = f;
        e.fc = (f > 24) ? 24 : f;
        e.err = (f > 24) || (a == 15 && f != 0);
        e.tag = tag;
        shift_bits(w, 12);
        wait_clks(HP);
        q.push_back(e);
        busy = 1;
        ser_latch = 1;
        ->go;
        wait (busy == 0);
        ser_latch = 0;
        wait_clks(HP);
    endtask

    // monitor: pop expected item and compare against the pins
    initial begin
        forever begin
            exp_t e;
            int hi, other, a_hi;
            @go;
            e = q.pop_front();
            wait_clks(6);
            check(pll_m == e.m, {"R2 m ", e.tag}, pll_m, e.m);
            check(pll_r == 4, "R4", pll_r, 4);
            check(fault == e.err, {"R7/R8/R9 fault ", e.tag}, fault, e.err);
            a_hi = (e.a + 1) % 16;
            if (e.fc != 0 && e.a != 15)
                check(pll_a == a_hi, {"R10 first slot ", e.tag}, pll_a, a_hi);
            hi = 0; other = 0;
            for (int i = 0; i < 24 * DIV; i++) begin
                if (e.a != 15 && pll_a == a_hi) hi++;
                else if (pll_a != e.a) other++;
                @(negedge clk);
            end
            check(hi == ((e.a == 15) ? 0 : e.fc * DIV), {"R6 duty ", e.tag}, hi,
                  (e.a == 15) ? 0 : e.fc * DIV);
            check(other == 0, {"R5/R8 stray A ", e.tag}, other, 0);
            busy = 0;
        end
    end

    initial begin
        wait_clks(200000);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clks(4);
        rst = 0;
        wait_clks(2);
        // R1 reset values
        check(pll_m == 0, "R1 m", pll_m, 0);
        check(pll_a == 0, "R1 a", pll_a, 0);
        check(fault == 0, "R1 fault", fault, 0);
        check(pll_r == 4, "R4 reset", pll_r, 4);

        send(5, 6, 0, "f0");          // R5 steady A
        send(2, 3, 7, "f7");          // R6
        send(7, 9, 24, "f24");        // R6 full
        send(1, 14, 1, "f1");         // R6 single slot, A+1 = 15
        send(3, 4, 30, "f30");        // R7 clamp + fault
        send(6, 15, 12, "a15");       // R8 hold, fault
        send(4, 10, 13, "clr");       // R9 cleared
        send(0, 15, 0, "a15f0");      // R8 boundary: valid

        // R3: partial word with no latch leaves outputs alone
        shift_bits(12'hFFF, 5);
        wait_clks(10);
        check(pll_m == 0, "R3 m held", pll_m, 0);
        check(pll_a == 15, "R3 a held", pll_a, 15);
        check(fault == 0, "R3 fault held", fault, 0);
        send(2, 5, 11, "after partial"); // full word flushes leftovers

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule